// File: doc/BRIEF.md
# Serial Port Hardware Flow Controller

This block performs automatic request-to-send / clear-to-send handshaking for one serial port. On the receive side it drives the outgoing request line. In automatic mode the line follows the receive buffer fill count against a programmable threshold. In manual mode it follows a software request bit. The pin polarity is programmable in both modes.

On the transmit side the incoming clear line is brought into the clock domain through a synchronising flop chain. The synchronised level, seen through its own polarity bit, decides whether the transmitter may begin a new character. The transmitter signals each point at which a character could start. The block answers in the same cycle with a permission that is only ever granted at such a point. A character that is already being shifted out is therefore never cut short.

Every transition of the synchronised clear line sets a sticky change flag. The flag is cleared by a write-one pulse and feeds a maskable modem interrupt.

Top module: `uart_hwflow`

## Requirements
- R1: With `auto_rts_en`=1, the request is asserted when `rx_fill` is strictly below a limit chosen by `rts_trig`, and withdrawn otherwise. The limits are: code 0 is 1, code 1 is 4, code 2 is 8, code 3 is 14, code 4 is 30, and codes 5 to 15 are 30. `rts_pin` reflects the inputs one clock later.
- R2: With `auto_rts_en`=0, the request equals `rts_soft_req`, one clock later.
- R3: When `rts_pol`=1 an asserted request drives `rts_pin` high; when `rts_pol`=0 it drives it low. `rts_sts` always equals the `rts_pin` level.
- R4: `cts_pin` passes through two synchronising flops. `cts_sts` shows the pin level two clocks after it was sampled. CTS counts as active when the synchronised level equals `cts_pol` (1 means active-high).
- R5: `tx_allow` is high only while `char_bound` is high and a registered permission is set. With `auto_cts_en`=1, the permission follows the active state of the synchronised CTS one clock later. With `auto_cts_en`=0, the permission is 1 from the second clock after reset onward.
- R6: Every change of the synchronised CTS level, in either direction, sets `cts_chg` on the following clock (the third clock after the pin change). The flag then stays set until cleared.
- R7: A `chg_clr` pulse clears `cts_chg` on the next clock, unless a new transition is detected in the same cycle, in which case the flag stays set.
- R8: `modem_irq` equals `cts_chg` ANDed with the `modem_ie` value of the previous cycle, and updates on the same clock as the flag.
- R9: While `rst` is high (synchronous, active-high), the clock drives `rts_pin` and `rts_sts` to the inactive level `~rts_pol`. It also clears `cts_chg`, `modem_irq` and the permission, and loads the synchroniser with 1 (so `cts_sts` is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_fill | input | FILL_W | Receive buffer fill count |
| rts_trig | input | 4 | Request withdrawal threshold code |
| auto_rts_en | input | 1 | Automatic request control enable |
| rts_soft_req | input | 1 | Software request bit for manual mode |
| rts_pol | input | 1 | Request pin active level (1 = high) |
| cts_pin | input | 1 | Raw asynchronous clear-to-send pin |
| cts_pol | input | 1 | Clear pin active level (1 = high) |
| auto_cts_en | input | 1 | Automatic transmit gating enable |
| char_bound | input | 1 | Transmitter is at a point where a character may start |
| chg_clr | input | 1 | Write-one clear of the change flag |
| modem_ie | input | 1 | Modem interrupt enable |
| rts_pin | output | 1 | Request-to-send pin |
| rts_sts | output | 1 | Read-only level of the request pin |
| cts_sts | output | 1 | Read-only synchronised clear pin level |
| tx_allow | output | 1 | A new character may start this cycle |
| cts_chg | output | 1 | Sticky clear-line change flag |
| modem_irq | output | 1 | Modem status interrupt |

## Verification
The hardest situation to reach is a detected CTS transition in the same cycle as a clear pulse. The transition only appears three clocks after the pin moves, so the stimulus toggles the pin, waits exactly two clocks and then pulses `chg_clr`. A single-cycle pin glitch gives two back-to-back transitions, and a random phase mixes pin, clear, fill, threshold code, polarities and mode bits. A behavioural reference model with a sample queue standing in for the synchroniser is compared against every output on every clock.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

  localparam int TRIG_W = 4;

  // Decoded fill level at which the request is withdrawn.
  function automatic int unsigned fill_limit(input logic [TRIG_W-1:0] code);
    case (code)
      4'd0:    fill_limit = 1;
      4'd1:    fill_limit = 4;
      4'd2:    fill_limit = 8;
      4'd3:    fill_limit = 14;
      default: fill_limit = 30;
    endcase
  endfunction

endpackage

// File: rtl/flowctl_sync.sv
module flowctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/flowctl_rts.sv
module flowctl_rts #(
  parameter int FILL_W = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          auto_en,
  input  logic                          sw_req,
  input  logic                          pol,
  input  logic [flowctl_pkg::TRIG_W-1:0] code,
  input  logic [FILL_W-1:0]             fill,
  output logic                          pin
);

  logic [FILL_W-1:0] limit;
  logic              want;

  always_comb begin
    limit = FILL_W'(flowctl_pkg::fill_limit(code));
    want  = auto_en ? (fill < limit) : sw_req;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= ~pol;
    else     pin <= pol ? want : ~want;
  end

  // R1
  rts_full_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && fill >= limit) |=> (pin == ~$past(pol)));

  // R1
  rts_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && fill == '0) |=> (pin == $past(pol)));

  // R2
  rts_soft_chk: assert property (@(posedge clk) disable iff (rst)
    (!auto_en) |=> (pin == ($past(sw_req) ~^ $past(pol))));

endmodule

// File: rtl/flowctl_cts.sv
module flowctl_cts #(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_s,
  input  logic pol,
  input  logic auto_en,
  input  logic chg_clr,
  input  logic irq_en,
  output logic permit,
  output logic chg_flag,
  output logic irq
);

  logic prev_q;
  logic active;
  logic toggled;
  logic flag_n;

  always_comb begin
    active  = pol ? cts_s : ~cts_s;
    toggled = cts_s ^ prev_q;
    flag_n  = toggled | (chg_flag & ~chg_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= IDLE_VAL;
      permit   <= 1'b0;
      chg_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      prev_q   <= cts_s;
      permit   <= ~auto_en | active;
      chg_flag <= flag_n;
      irq      <= flag_n & irq_en;
    end
  end

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_en && (cts_s != pol)) |=> !permit);

  // R6
  chg_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cts_s != prev_q) |=> chg_flag);

  // R6
  chg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && !chg_clr) |=> chg_flag);

  // R7
  chg_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && chg_clr && (cts_s == prev_q)) |=> !chg_flag);

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> chg_flag);

endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow #(
  parameter int FILL_W    = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [FILL_W-1:0]              rx_fill,
  input  logic [flowctl_pkg::TRIG_W-1:0] rts_trig,
  input  logic                           auto_rts_en,
  input  logic                           rts_soft_req,
  input  logic                           rts_pol,
  input  logic                           cts_pin,
  input  logic                           cts_pol,
  input  logic                           auto_cts_en,
  input  logic                           char_bound,
  input  logic                           chg_clr,
  input  logic                           modem_ie,
  output logic                           rts_pin,
  output logic                           rts_sts,
  output logic                           cts_sts,
  output logic                           tx_allow,
  output logic                           cts_chg,
  output logic                           modem_irq
);

  localparam logic CTS_IDLE = 1'b1;

  logic cts_s;
  logic permit;

  flowctl_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(CTS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cts_pin),
    .q   (cts_s)
  );

  flowctl_rts #(.FILL_W(FILL_W)) u_rts (
    .clk     (clk),
    .rst     (rst),
    .auto_en (auto_rts_en),
    .sw_req  (rts_soft_req),
    .pol     (rts_pol),
    .code    (rts_trig),
    .fill    (rx_fill),
    .pin     (rts_pin)
  );

  flowctl_cts #(.IDLE_VAL(CTS_IDLE)) u_cts (
    .clk      (clk),
    .rst      (rst),
    .cts_s    (cts_s),
    .pol      (cts_pol),
    .auto_en  (auto_cts_en),
    .chg_clr  (chg_clr),
    .irq_en   (modem_ie),
    .permit   (permit),
    .chg_flag (cts_chg),
    .irq      (modem_irq)
  );

  assign rts_sts  = rts_pin;
  assign cts_sts  = cts_s;
  assign tx_allow = char_bound & permit;

  // R5
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_cts_en && (cts_s != cts_pol)) |=> !(tx_allow && $past(auto_cts_en)
      && $stable(auto_cts_en)));

endmodule

// File: tb/uart_hwflow_bench.sv
`timescale 1ns/1ps
module uart_hwflow_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] rx_fill = '0;
  logic [3:0] rts_trig = '0;
  logic auto_rts_en = 0, rts_soft_req = 0, rts_pol = 0;
  logic cts_pin = 1, cts_pol = 0, auto_cts_en = 0;
  logic char_bound = 0, chg_clr = 0, modem_ie = 0;
  logic rts_pin, rts_sts, cts_sts, tx_allow, cts_chg, modem_irq;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit started = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  uart_hwflow u_uart_hwflow (
    .clk(clk), .rst(rst), .rx_fill(rx_fill), .rts_trig(rts_trig),
    .auto_rts_en(auto_rts_en), .rts_soft_req(rts_soft_req), .rts_pol(rts_pol),
    .cts_pin(cts_pin), .cts_pol(cts_pol), .auto_cts_en(auto_cts_en),
    .char_bound(char_bound), .chg_clr(chg_clr), .modem_ie(modem_ie),
    .rts_pin(rts_pin), .rts_sts(rts_sts), .cts_sts(cts_sts),
    .tx_allow(tx_allow), .cts_chg(cts_chg), .modem_irq(modem_irq)
  );

  // Behavioural reference model
  int lim_tab[16];
  int hist[$];
  bit m_rts, m_prev, m_gate, m_flag, m_irq, m_clr_seen, m_rst_seen;

  initial begin
    for (int k = 0; k < 16; k++) lim_tab[k] = 30;
    lim_tab[0] = 1; lim_tab[1] = 4; lim_tab[2] = 8; lim_tab[3] = 14;
  end

  always @(posedge clk) begin
    int  s_old;
    bit  act, want, moved;
    started = 1;
    m_rst_seen = rst;
    m_clr_seen = chg_clr;
    if (rst) begin
      hist   = {1, 1};
      m_rts  = ~rts_pol;
      m_prev = 1; m_gate = 0; m_flag = 0; m_irq = 0;
    end else begin
      s_old = hist[0];
      void'(hist.pop_front());
      hist.push_back(int'(cts_pin));
      want  = auto_rts_en ? (int'(rx_fill) < lim_tab[rts_trig]) : rts_soft_req;
      m_rts = rts_pol ? want : ~want;
      act   = (s_old == int'(cts_pol));
      moved = (s_old != int'(m_prev));
      m_prev = (s_old != 0);
      m_gate = !auto_cts_en || act;
      m_flag = moved || (m_flag && !chg_clr);
      m_irq  = m_flag && modem_ie;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (m_rst_seen) begin
        chk("R9 rts_pin",  rts_pin,  m_rts);
        chk("R9 cts_chg",  cts_chg,  1'b0);
        chk("R9 irq",      modem_irq, 1'b0);
        chk("R9 cts_sts",  cts_sts,  1'b1);
        chk("R9 tx_allow", tx_allow, 1'b0);
      end else begin
        chk(auto_rts_en ? "R1 rts_pin" : "R2 rts_pin", rts_pin, m_rts);
        chk("R3 rts_sts", rts_sts, m_rts);
        chk("R4 cts_sts", cts_sts, hist[0] != 0);
        chk("R5 tx_allow", tx_allow, char_bound && m_gate);
        chk(m_clr_seen ? "R7 cts_chg" : "R6 cts_chg", cts_chg, m_flag);
        chk("R8 modem_irq", modem_irq, m_irq);
      end
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      cyc++;
      char_bound = (cyc % 3) == 0;
      chg_clr    = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("[TB] FAIL watchdog R9: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    // R9: reset state
    step(4);
    rst = 0;
    step(3);

    // R2, R3: manual request through both polarities
    rts_soft_req = 1; step(3);
    rts_pol = 1;      step(3);
    rts_soft_req = 0; step(3);
    rts_pol = 0;      step(3);

    // R1: threshold table around each limit
    auto_rts_en = 1;
    for (int c = 0; c < 7; c++) begin
      int lim;
      lim = lim_tab[c];
      rts_trig = 4'(c);
      rts_pol  = c[0];
      rx_fill = 6'(0);       step(2);
      rx_fill = 6'(lim - 1); step(2);
      rx_fill = 6'(lim);     step(2);
      rx_fill = 6'(lim + 1); step(2);
      rx_fill = 6'(32);      step(2);
    end
    rts_trig = 4'd15; rx_fill = 6'd29; step(2);
    rx_fill = 6'd30; step(2);
    rts_pol = 0; auto_rts_en = 0;

    // R4, R5, R6: clear line activity with gating
    auto_cts_en = 1; modem_ie = 1;
    cts_pin = 0; step(6);
    chg_clr = 1; step(1); step(3);          // R7 plain clear
    cts_pin = 1; step(6);                   // gate drops
    cts_pin = 0; step(2);
    chg_clr = 1; step(1); step(3);          // R7 clear collides with new edge
    chg_clr = 1; step(1); step(2);
    modem_ie = 0; cts_pin = 1; step(5);     // R8 masked
    modem_ie = 1; step(2);
    cts_pol = 1; step(5);                   // active-high clear line
    cts_pin = 0; step(1); cts_pin = 1; step(5); // glitch, two transitions
    auto_cts_en = 0; cts_pin = 0; step(5);  // gating off while inactive
    chg_clr = 1; step(1); step(2);

    // Mixed random phase
    for (int k = 0; k < 400; k++) begin
      cts_pin      = 1'($urandom_range(0, 1));
      chg_clr      = ($urandom_range(0, 4) == 0);
      rx_fill      = 6'($urandom_range(0, 40));
      rts_trig     = 4'($urandom_range(0, 15));
      rts_soft_req = 1'($urandom_range(0, 1));
      modem_ie     = 1'($urandom_range(0, 1));
      if (k % 37 == 0) begin
        auto_rts_en = ~auto_rts_en;
        rts_pol     = 1'($urandom_range(0, 1));
        cts_pol     = 1'($urandom_range(0, 1));
        auto_cts_en = ~auto_cts_en;
      end
      @(posedge clk); #1; cyc++;
      char_bound = 1'($urandom_range(0, 1));
    end

    // R9: reset again from an active state
    rst = 1; step(3);
    rst = 0; step(3);
    finish_run();
  end

endmodule